// File: doc/BRIEF.md
# Asynchronous static-memory write-cycle controller with wait stretching

This block turns one request on a simple internal valid/ready handshake into a single write cycle on an asynchronous static-memory bus. When a request is taken, the block latches the address and data, drives chip-select low and holds it through an address-setup phase of a programmable number of clocks. It then drives the active-low write strobe low for a programmable data-phase count. The address, data and chip-select stay constant for the whole cycle. They are released one clock after the strobe rises, and a one-cycle done pulse marks that clock.

The external device can hold off the end of the strobe with an active-low wait pin. That pin is asynchronous to the clock and passes through a two-stage synchronizer. The block watches it from the start of the setup phase. If it has been seen active, the strobe ends at the later of two points: the data-phase count running out, or four clocks after the synchronized release. The full data phase is not replayed after a release. A release that happens a few clocks before the strobe falls can therefore still lengthen the strobe. If wait stays active too long, a timeout ends the cycle and flags an error together with done. A configuration bit turns wait handling off, and the strobe is then exactly the programmed count.

Top module: `sram_wr_ctrl`

## Requirements
- R1: After reset, mem_cs_n and mem_we_n are 1, done and tmo_err are 0, req_ready is 1 and mem_addr and mem_data are 0.
- R2: A request is taken in a clock where req_valid and req_ready are both 1. mem_cs_n is 0 from the next clock, and mem_we_n falls after L setup clocks. L is cfg_setup, and a value of 0 counts as 1.
- R3: With no wait seen, mem_we_n stays 0 for exactly D clocks. D is cfg_data over its full range of 1 to 255, and a value of 0 counts as 1.
- R4: mem_wait_n is read through a two-flop synchronizer. A level driven in clock p takes effect in clock p+2.
- R5: Let r be the first clock in which the synchronized wait is inactive after being active during the setup or strobe phase. With wait enabled, the strobe's first high clock is the later of S+D and r+4, where S is the first low clock of the strobe.
- R6: A wait release whose synchronized edge comes shortly before the strobe falls still lengthens the strobe whenever r+4 is later than S+D.
- R7: With a large D and a release that comes late, mem_we_n rises exactly 4 clocks after r. The programmed count is not restarted.
- R8: With cfg_wait_en at 0, mem_wait_n has no effect and the strobe lasts exactly D clocks.
- R9: mem_addr, mem_data and mem_cs_n hold their values while mem_cs_n is 0. One clock after mem_we_n rises, mem_cs_n returns to 1, mem_addr and mem_data return to 0, and done is 1 for exactly that one clock.
- R10: Count the strobe clocks in which D has expired but wait still holds the strobe. When that count reaches TMO_CYC, the strobe ends, giving a strobe length of D+TMO_CYC-1. tmo_err is then 1 together with done.
- R11: req_ready is 0 while a cycle is in progress, and a req_valid pulse during that time is ignored: no new cycle starts after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request |
| req_ready | output | 1 | Block idle, request accepted this clock |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| cfg_setup | input | SW | Address-setup length in clocks (0 acts as 1) |
| cfg_data | input | DTW | Data-phase length in clocks (0 acts as 1) |
| cfg_wait_en | input | 1 | 1 lets the wait pin stretch the strobe |
| mem_addr | output | AW | Memory address bus |
| mem_data | output | DW | Memory data bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_wait_n | input | 1 | Active-low asynchronous wait from the device |
| done | output | 1 | One-clock pulse at the end of a cycle |
| tmo_err | output | 1 | With done: the cycle ended by timeout |

## Verification
Random cycles mix setup and data lengths with wait pulses that start at varied points and release at varied points. These include releases long before the strobe, just before it, during it and after the count expires, so the release-plus-four rule is told apart from a replayed data count. Directed cycles cover the following:
- data counts of 0 and 255;
- a release two clocks before the strobe falls, which must still stretch it;
- a release after a count of 200, where the strobe must rise exactly four clocks later;
- wait held with handling disabled, which must change nothing;
- wait never released, which must end in a timeout;
- a request pulse during a busy cycle, which must be dropped.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } wr_state_e;

  // programmed phase length: a zero setting behaves as one clock
  function automatic logic [31:0] phase_len(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/sram_wait_sync.sv
module sram_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '1;
    else        shreg <= {shreg[STAGES-2:0], async_n};
  end

  assign sync_n = shreg[STAGES-1];
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer
  import sram_wr_pkg::*;
#(
  parameter int SW  = 4,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           in_setup,
  input  logic           in_strobe,
  input  logic [SW-1:0]  setup_cfg,
  input  logic [DTW-1:0] data_cfg,
  output logic           setup_done,
  output logic           data_done
);
  logic [DTW-1:0] pcnt;
  logic [31:0]    cnt_w, setup_lim, data_lim;

  assign cnt_w     = 32'(pcnt);
  assign setup_lim = phase_len(32'(setup_cfg));
  assign data_lim  = phase_len(32'(data_cfg));
  assign setup_done = in_setup  && (cnt_w >= setup_lim);
  assign data_done  = in_strobe && (cnt_w >= data_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (load)
      pcnt <= DTW'(1);
    else if ((in_setup && !setup_done) || (in_strobe && !data_done))
      pcnt <= pcnt + 1'b1;
  end

  AST_DATA_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && !data_done) |=> in_strobe);  // R3
endmodule

// File: rtl/sram_wait_track.sv
module sram_wait_track #(
  parameter int REL_CYC = 4,
  parameter int TMO_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_act,
  input  logic in_window,
  input  logic in_strobe,
  input  logic data_done,
  output logic rel_ok,
  output logic tmo_hit
);
  localparam int RW = $clog2(REL_CYC + 1);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [RW-1:0] rcnt;
  logic [TW-1:0] tcnt;
  logic          blocked;

  // release countdown: armed while wait is active, runs down after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rcnt <= '0;
    else if (!in_window)   rcnt <= '0;
    else if (wait_act)     rcnt <= RW'(REL_CYC);
    else if (rcnt != '0)   rcnt <= rcnt - 1'b1;
  end

  assign rel_ok  = !wait_act && (rcnt <= RW'(1));
  assign blocked = in_strobe && data_done && !rel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tcnt <= '0;
    else if (!blocked) tcnt <= '0;
    else               tcnt <= tcnt + 1'b1;
  end

  assign tmo_hit = blocked && (tcnt == TW'(TMO_CYC - 1));

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && wait_act && !tmo_hit) |=> in_strobe);  // R5
endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int SW          = 4,
  parameter int DTW         = 8,
  parameter int REL_CYC     = 4,
  parameter int TMO_CYC     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_data,
  input  logic [SW-1:0]  cfg_setup,
  input  logic [DTW-1:0] cfg_data,
  input  logic           cfg_wait_en,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data,
  output logic           mem_cs_n,
  output logic           mem_we_n,
  input  logic           mem_wait_n,
  output logic           done,
  output logic           tmo_err
);
  wr_state_e      state, state_nx;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic [SW-1:0]  setup_q;
  logic [DTW-1:0] dlen_q;
  logic           wen_q, err_pend, done_q, tmo_q;

  // named internal events
  logic accept, in_setup, in_strobe, in_window;
  logic setup_done, data_done, rel_ok, tmo_hit, strobe_end;
  logic wait_sync_n, wait_act;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign in_setup  = (state == ST_SETUP);
  assign in_strobe = (state == ST_STROBE);
  assign in_window = in_setup || in_strobe;
  assign wait_act  = wen_q && !wait_sync_n;
  assign strobe_end = in_strobe && ((data_done && rel_ok) || tmo_hit);

  sram_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_n(mem_wait_n), .sync_n(wait_sync_n)
  );

  sram_phase_timer #(.SW(SW), .DTW(DTW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(accept || setup_done),
    .in_setup(in_setup), .in_strobe(in_strobe),
    .setup_cfg(setup_q), .data_cfg(dlen_q),
    .setup_done(setup_done), .data_done(data_done)
  );

  sram_wait_track #(.REL_CYC(REL_CYC), .TMO_CYC(TMO_CYC)) u_track (
    .clk(clk), .rst_n(rst_n), .wait_act(wait_act),
    .in_window(in_window), .in_strobe(in_strobe), .data_done(data_done),
    .rel_ok(rel_ok), .tmo_hit(tmo_hit)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (accept)     state_nx = ST_SETUP;
      ST_SETUP:  if (setup_done) state_nx = ST_STROBE;
      ST_STROBE: if (strobe_end) state_nx = ST_HOLD;
      ST_HOLD:                   state_nx = ST_IDLE;
      default:                   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      setup_q  <= '0;
      dlen_q   <= '0;
      wen_q    <= 1'b0;
      err_pend <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= (state == ST_HOLD);
      tmo_q  <= (state == ST_HOLD) && err_pend;
      if (accept) begin
        addr_q   <= req_addr;
        data_q   <= req_data;
        setup_q  <= cfg_setup;
        dlen_q   <= cfg_data;
        wen_q    <= cfg_wait_en;
        err_pend <= 1'b0;
      end else if (in_strobe && tmo_hit) begin
        err_pend <= 1'b1;
      end
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign mem_cs_n  = (state == ST_IDLE);
  assign mem_we_n  = !in_strobe;
  assign mem_addr  = mem_cs_n ? '0 : addr_q;
  assign mem_data  = mem_cs_n ? '0 : data_q;
  assign done      = done_q;
  assign tmo_err   = tmo_q;

  AST_WE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);  // R9
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_data)));  // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9
  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_cs_n && $past(!mem_cs_n)));  // R9
  AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> done);  // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);  // R11
endmodule

// File: tb/sram_wr_ctrl_tb.sv
module sram_wr_ctrl_tb;
  localparam int AW = 16, DW = 16, SW = 4, DTW = 8, TMO = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_ready, cfg_wait_en, mem_cs_n, mem_we_n, mem_wait_n, done, tmo_err;
  logic [AW-1:0]  req_addr, mem_addr;
  logic [DW-1:0]  req_data, mem_data;
  logic [SW-1:0]  cfg_setup;
  logic [DTW-1:0] cfg_data;

  sram_wr_ctrl #(.AW(AW), .DW(DW), .SW(SW), .DTW(DTW), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .cfg_setup(cfg_setup),
    .cfg_data(cfg_data), .cfg_wait_en(cfg_wait_en), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_wait_n(mem_wait_n), .done(done), .tmo_err(tmo_err)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // expected first high strobe clock, relative to the request clock
  function automatic int exp_end(input int l, input int d, input bit wen, input bit won,
                                 input int p1, input bit tmo);
    int s;
    s = eff(l) + 1;
    if (tmo)             return s + eff(d) - 1 + TMO;
    else if (wen && won) return imax(s + eff(d), p1 + 2 + 4);
    else                 return s + eff(d);
  endfunction

  task automatic run_write(input logic [15:0] ad, input logic [15:0] dt, input int l, input int d,
                           input bit wen, input bit won, input int p0, input int p1,
                           input bit poke, input bit exp_tmo, input string tag);
    int cs_i = -1, s_i = -1, e_i = -1, d_i = -1;
    bit stable_ok = 1, rdy_ok = 1, rel_ok = 1, tmo_seen = 0;
    int e_exp;
    e_exp = exp_end(l, d, wen, won, p1, exp_tmo);
    cfg_setup   = SW'(l);
    cfg_data    = DTW'(d);
    cfg_wait_en = wen;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (k > 0) begin
        if (cs_i < 0 && !mem_cs_n) cs_i = k;
        if (s_i < 0 && !mem_we_n) s_i = k;
        if (s_i >= 0 && e_i < 0 && mem_we_n) e_i = k;
        if (!mem_cs_n) begin
          if (mem_addr != ad || mem_data != dt) stable_ok = 0;
          if (req_ready) rdy_ok = 0;
        end
        if (done && d_i < 0) begin
          d_i = k;
          tmo_seen = tmo_err;
          rel_ok = mem_cs_n && (mem_addr == '0) && (mem_data == '0);
        end
      end
      req_valid  = (k == 0) || (poke && k == 3);
      req_addr   = (k == 0) ? ad : ~ad;
      req_data   = (k == 0) ? dt : ~dt;
      mem_wait_n = !(won && k >= p0 && k < p1);
      if (d_i >= 0) break;
    end
    req_valid = 0;
    mem_wait_n = 1;
    chk(cs_i == 1, {"R2 cs_n falls ", tag}, cs_i, 1);
    chk(s_i == eff(l) + 1, {"R2 strobe start ", tag}, s_i, eff(l) + 1);
    chk(e_i == e_exp, {tag, " strobe end"}, e_i, e_exp);
    chk(d_i == e_i + 1 && rel_ok, {"R9 done/release ", tag}, d_i, e_i + 1);
    chk(stable_ok, {"R9 bus stable ", tag}, stable_ok, 1);
    chk(rdy_ok, {"R11 ready low while busy ", tag}, rdy_ok, 1);
    chk(tmo_seen == exp_tmo, {"R10 tmo flag ", tag}, tmo_seen, exp_tmo);
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk(mem_cs_n && req_ready, "R11 busy request ignored", mem_cs_n, 1);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; req_valid = 0; req_addr = '0; req_data = '0;
    cfg_setup = '0; cfg_data = '0; cfg_wait_en = 0; mem_wait_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n && mem_we_n && !done && !tmo_err && req_ready && mem_addr == '0 && mem_data == '0,
        "R1 reset state", {mem_cs_n, mem_we_n, done, tmo_err, req_ready}, 5'b11001);

    // directed corner cases
    run_write(16'h1234, 16'hABCD, 3, 5, 1, 0, 0, 0, 0, 0, "R3 plain");
    run_write(16'h0001, 16'h0002, 0, 0, 1, 0, 0, 0, 0, 0, "R3 zero lengths");
    run_write(16'hFFFF, 16'h5555, 15, 255, 0, 0, 0, 0, 0, 0, "R3 max count");
    run_write(16'h2222, 16'h3333, 10, 3, 1, 1, 0, 9, 0, 0, "R6 pre-strobe release");
    run_write(16'h4444, 16'h6666, 2, 200, 1, 1, 0, 220, 0, 0, "R7 late release long count");
    run_write(16'h7777, 16'h8888, 2, 4, 1, 1, 1, 12, 0, 0, "R5 R4 overlap release");
    run_write(16'h9999, 16'hAAAA, 2, 4, 0, 1, 0, 30, 0, 0, "R8 wait disabled");
    run_write(16'hBBBB, 16'hCCCC, 2, 6, 1, 1, 0, 100000, 0, 1, "R10 timeout");
    run_write(16'hDDDD, 16'hEEEE, 4, 8, 1, 0, 0, 0, 1, 0, "R11 busy poke");

    // constrained random cycles
    for (int i = 0; i < 30; i++) begin
      int l, d, p0, p1;
      bit wen, won;
      l   = $urandom_range(0, 6);
      d   = $urandom_range(0, 12);
      wen = ($urandom % 4) != 0;
      won = $urandom % 2;
      p0  = $urandom_range(0, eff(l) + eff(d) - 2);
      p1  = p0 + $urandom_range(1, eff(l) + eff(d) + 12);
      run_write(16'($urandom), 16'($urandom), l, d, wen, won, p0, p1, 0, 0, "R5 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule